// File: doc/BRIEF.md
# I2C Master Channel Register File

This block holds the control and status registers of one I2C master channel. A bus agent reads and writes a 64-byte window through a simple write-strobe interface with combinational read data. Writes are trimmed to the bits each register implements. Interrupt flags are cleared by writing ones. Writes to the command register are turned into one-cycle command pulses for the bus engine that drives SCL and SDA. The engine reports completion events, received bytes, its busy flag and its state code, and these are folded back into the readable registers.

A receive that completes sets a receive-done flag, and that flag never clears itself. While it is set, any further receive command is parked in the command register rather than passed to the engine. Software acknowledges the flag by writing a one to it, and that same write releases the parked receive to the engine. The status acknowledge therefore also paces the received bytes, one at a time.

Top module: `i2c_chan_regs`

## Requirements
- R1: After reset every readable register returns 0, `irq` is low and `engCmd` is 0.
- R2: Writes keep only these bits: function control (offset 0x00) `0x0071C3FF`; first timing (0x04) `0x0FFFFF0F`; second timing (0x08) `0x7`; interrupt enable (0x0C) `0x7FFF`. An unmapped offset reads 0.
- R3: At status offset 0x10, writing a 1 to a bit clears it and writing a 0 leaves it unchanged. The status bits are: 0 byte acked, 1 byte nacked, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal stop.
- R4: A pulse on `engEvt[i]` sets status bit i. If the set and a clear of the same bit fall in the same cycle, the set wins.
- R5: `irq` is high exactly when some status bit and its enable bit (offset 0x0C, same position) are both 1.
- R6: A write to the byte buffer (0x20) stores bits [7:0] and zeroes the rest. A receive-done event loads `engRxData` into read bits [15:8] and zeroes bits [7:0].
- R7: A write to the command register (0x14) has no effect unless function-control bit 0 (master enable) is 1. When it takes effect, it replaces bits [15:0] of the command register.
- R8: Command bits 0 (start), 1 (transmit) and 5 (stop) of an accepted write appear on `engCmd` at the same positions for exactly the one cycle after the write, and they are not kept in the register.
- R9: If receive done is clear, an accepted write with command bit 3 (receive) or bit 4 (receive-last) set passes those bits to `engCmd` the cycle after the write and does not keep them.
- R10: If receive done is set, receive bits 3 and 4 are kept in the command register and do not reach `engCmd`. A status write with bit 2 equal to 1 clears receive done, puts the kept bits on `engCmd` the next cycle, and clears them from the register. A status write with bit 2 equal to 0 releases nothing.
- R11: A command-register read returns `engBusy` in bit 16 and `engState` in bits [22:19].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte offset into the window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| engCmd | output | 6 | One-cycle command pulses to the bus engine |
| engEvt | input | 6 | Completion event pulses from the engine, one per status bit |
| engRxData | input | 8 | Received byte, valid with `engEvt[2]` |
| engBusy | input | 1 | Engine reports that the bus is busy |
| engState | input | 4 | Engine state code |
| irq | output | 1 | Channel interrupt request |

## Verification
Two things can hit the same status bit in one cycle: a software write that clears it and an engine event that sets it. The bench drives a one-to-clear write to the nacked bit together with an `engEvt` pulse on that bit, then reads the bit back and expects it still set. The receive path is the second place where two actions meet. The test parks a receive behind an unacknowledged receive-done flag. It then checks that an unrelated status write and a status write with a zero in bit 2 both leave `engCmd` quiet, and that only the bit-2 acknowledge produces the receive pulse, in the cycle right after that write.

// File: rtl/i2c_chan_pkg.sv
package i2c_chan_pkg;
  localparam int OFF_FUNC = 'h00;
  localparam int OFF_TIM1 = 'h04;
  localparam int OFF_TIM2 = 'h08;
  localparam int OFF_IEN  = 'h0C;
  localparam int OFF_STS  = 'h10;
  localparam int OFF_CMD  = 'h14;
  localparam int OFF_BUF  = 'h20;

  localparam logic [31:0] MASK_FUNC = 32'h0071_C3FF;
  localparam logic [31:0] MASK_TIM1 = 32'h0FFF_FF0F;
  localparam logic [31:0] MASK_TIM2 = 32'h0000_0007;
  localparam logic [31:0] MASK_IEN  = 32'h0000_7FFF;

  localparam int CMD_START  = 0;
  localparam int CMD_TX     = 1;
  localparam int CMD_RX     = 3;
  localparam int CMD_RXLAST = 4;
  localparam int CMD_STOP   = 5;
  localparam int STS_RXDONE = 2;

  typedef struct packed {
    logic wrFunc;
    logic wrTim1;
    logic wrTim2;
    logic wrIen;
    logic wrSts;
    logic wrCmd;
    logic wrBuf;
    logic rxNow;
    logic rxRelease;
  } regStrobe_t;
endpackage

// File: rtl/i2c_chan_ctrl.sv
module i2c_chan_ctrl
  import i2c_chan_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        wdRxBits,
  input  logic              wdAckRx,
  input  logic              fnEn,
  input  logic              rxDone,
  input  logic              rxHeld,
  output regStrobe_t        stb
);
  logic cmdHit;

  always_comb begin
    stb = '0;
    cmdHit = regWr && (regAddr == ADDR_W'(OFF_CMD));
    stb.wrFunc = regWr && (regAddr == ADDR_W'(OFF_FUNC));
    stb.wrTim1 = regWr && (regAddr == ADDR_W'(OFF_TIM1));
    stb.wrTim2 = regWr && (regAddr == ADDR_W'(OFF_TIM2));
    stb.wrIen  = regWr && (regAddr == ADDR_W'(OFF_IEN));
    stb.wrSts  = regWr && (regAddr == ADDR_W'(OFF_STS));
    stb.wrBuf  = regWr && (regAddr == ADDR_W'(OFF_BUF));
    stb.wrCmd  = cmdHit && fnEn;
    // a new receive goes straight out only when no unacknowledged byte waits
    stb.rxNow  = stb.wrCmd && (|wdRxBits) && !rxDone;
    // acknowledging receive-done releases a parked receive
    stb.rxRelease = stb.wrSts && wdAckRx && rxDone && rxHeld;
  end
endmodule

// File: rtl/i2c_chan_dp.sv
module i2c_chan_dp
  import i2c_chan_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int EVT_W   = 6,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic [EVT_W-1:0]   engCmd,
  input  logic [EVT_W-1:0]   engEvt,
  input  logic [7:0]         engRxData,
  input  logic               engBusy,
  input  logic [STATE_W-1:0] engState,
  output logic               irq,
  output logic               fnEn,
  output logic               rxDone,
  output logic               rxHeld,
  output logic [EVT_W-1:0]   stsQ
);
  localparam logic [15:0] PULSE_BITS = 16'((1 << CMD_START) | (1 << CMD_TX) | (1 << CMD_STOP));
  localparam logic [15:0] RX_BITS    = 16'((1 << CMD_RX) | (1 << CMD_RXLAST));
  localparam int PAD_W = 32 - 16 - 3 - STATE_W;

  logic [31:0] funcQ, tim1Q, tim2Q, ienQ;
  logic [15:0] cmdQ;
  logic [15:0] bufQ;
  logic [EVT_W-1:0] stsClr;

  assign fnEn   = funcQ[0];
  assign rxDone = stsQ[STS_RXDONE];
  assign rxHeld = |(cmdQ & RX_BITS);
  assign stsClr = stb.wrSts ? regWdata[EVT_W-1:0] : '0;
  assign irq    = |(stsQ & ienQ[EVT_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcQ <= '0; tim1Q <= '0; tim2Q <= '0; ienQ <= '0;
    end else begin
      if (stb.wrFunc) funcQ <= regWdata & MASK_FUNC;
      if (stb.wrTim1) tim1Q <= regWdata & MASK_TIM1;
      if (stb.wrTim2) tim2Q <= regWdata & MASK_TIM2;
      if (stb.wrIen)  ienQ  <= regWdata & MASK_IEN;
    end
  end

  // status: events override a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsQ <= '0;
    else       stsQ <= (stsQ & ~stsClr) | engEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ   <= '0;
      engCmd <= '0;
    end else begin
      engCmd <= '0;
      if (stb.wrCmd) begin
        cmdQ   <= regWdata[15:0] & ~PULSE_BITS & ~(stb.rxNow ? RX_BITS : 16'h0);
        engCmd <= EVT_W'(regWdata[15:0] & (PULSE_BITS | (stb.rxNow ? RX_BITS : 16'h0)));
      end else if (stb.rxRelease) begin
        cmdQ   <= cmdQ & ~RX_BITS;
        engCmd <= EVT_W'(cmdQ & RX_BITS);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     bufQ <= '0;
    else if (engEvt[STS_RXDONE])   bufQ <= {engRxData, 8'h00};
    else if (stb.wrBuf)            bufQ <= {8'h00, regWdata[7:0]};
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(OFF_FUNC): regRdata = funcQ;
      ADDR_W'(OFF_TIM1): regRdata = tim1Q;
      ADDR_W'(OFF_TIM2): regRdata = tim2Q;
      ADDR_W'(OFF_IEN):  regRdata = ienQ;
      ADDR_W'(OFF_STS):  regRdata = 32'(stsQ);
      ADDR_W'(OFF_CMD):  regRdata = {{PAD_W{1'b0}}, engState, 2'b00, engBusy, cmdQ};
      ADDR_W'(OFF_BUF):  regRdata = {16'h0, bufQ};
      default:           regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_chan_regs.sv
module i2c_chan_regs
  import i2c_chan_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int EVT_W   = 6,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic [EVT_W-1:0]   engCmd,
  input  logic [EVT_W-1:0]   engEvt,
  input  logic [7:0]         engRxData,
  input  logic               engBusy,
  input  logic [STATE_W-1:0] engState,
  output logic               irq
);
  regStrobe_t       stb;
  logic             fnEn, rxDone, rxHeld;
  logic [EVT_W-1:0] stsQ;

  i2c_chan_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWr(regWr), .regAddr(regAddr),
    .wdRxBits(regWdata[CMD_RXLAST:CMD_RX]), .wdAckRx(regWdata[STS_RXDONE]),
    .fnEn(fnEn), .rxDone(rxDone), .rxHeld(rxHeld), .stb(stb)
  );

  i2c_chan_dp #(.ADDR_W(ADDR_W), .EVT_W(EVT_W), .STATE_W(STATE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .engCmd(engCmd), .engEvt(engEvt), .engRxData(engRxData),
    .engBusy(engBusy), .engState(engState), .irq(irq),
    .fnEn(fnEn), .rxDone(rxDone), .rxHeld(rxHeld), .stsQ(stsQ)
  );
endmodule

// File: rtl/i2c_chan_regs_chk.sv
module i2c_chan_regs_chk #(
  parameter int ADDR_W = 6,
  parameter int EVT_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [EVT_W-1:0]  engCmd,
  input logic [EVT_W-1:0]  engEvt,
  input logic              irq,
  input logic              fnEn,
  input logic              rxDone,
  input logic              rxHeld,
  input logic [EVT_W-1:0]  stsQ
);
  logic cmdWr, stsWr;
  assign cmdWr = regWr && (regAddr == ADDR_W'('h14));
  assign stsWr = regWr && (regAddr == ADDR_W'('h10));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && fnEn && rxDone && (regWdata[3] || regWdata[4])) |=> (engCmd[4:3] == 2'b00));

  // R10
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && regWdata[2] && rxDone && rxHeld) |=> (engCmd[4:3] != 2'b00));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && regWdata[0] && !engEvt[0]) |=> !stsQ[0]);

  // R4
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    engEvt[1] |=> stsQ[1]);

  // R7
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !fnEn) |=> (engCmd == '0));

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((engCmd != '0) && !regWr) |=> (engCmd == '0));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsQ == '0) |-> !irq);
endmodule

bind i2c_chan_regs i2c_chan_regs_chk #(.ADDR_W(ADDR_W), .EVT_W(EVT_W)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .engCmd(engCmd), .engEvt(engEvt), .irq(irq), .fnEn(fnEn), .rxDone(rxDone),
  .rxHeld(rxHeld), .stsQ(stsQ)
);

// File: tb/tb_i2c_chan_regs.sv
module tb_i2c_chan_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [5:0]  engCmd;
  logic [5:0]  engEvt = '0;
  logic [7:0]  engRxData = '0;
  logic        engBusy = 1'b0;
  logic [3:0]  engState = '0;
  logic        irq;
  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_chan_regs dut (.*);

  // {addr, write data, expected readback}
  localparam logic [69:0] VEC [0:9] = '{
    {6'h00, 32'hFFFF_FFFF, 32'h0071_C3FF},
    {6'h04, 32'hFFFF_FFFF, 32'h0FFF_FF0F},
    {6'h08, 32'hFFFF_FFFF, 32'h0000_0007},
    {6'h0C, 32'hFFFF_FFFF, 32'h0000_7FFF},
    {6'h00, 32'h1234_5678, 32'h0030_4278},
    {6'h04, 32'h1234_5678, 32'h0234_5608},
    {6'h08, 32'h0000_0005, 32'h0000_0005},
    {6'h0C, 32'h0000_A5A5, 32'h0000_25A5},
    {6'h18, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h20, 32'hABCD_1234, 32'h0000_0034}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic evt(input logic [5:0] e, input logic [7:0] data);
    @(negedge clk);
    engEvt = e; engRxData = data;
    @(negedge clk);
    engEvt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      rd(6'(i * 4), r);
      check("R1", r, 32'h0);
    end
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 engCmd", 32'(engCmd), 32'h0);

    // R2 masks, table driven
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], r);
      check("R2/R6 table", r, VEC[i][31:0]);
    end

    // R7 command ignored while master enable clear
    wr(6'h00, 32'h0);
    wr(6'h14, 32'h0000_8123);
    check("R7 gated engCmd", 32'(engCmd), 32'h0);
    rd(6'h14, r);
    check("R7 gated reg", r, 32'h0);
    wr(6'h00, 32'h1);

    // R8 start/tx/stop pulse one cycle, not kept
    wr(6'h14, 32'h0000_0023);
    check("R8 pulse", 32'(engCmd), 32'h23);
    @(negedge clk);
    check("R8 one cycle", 32'(engCmd), 32'h0);
    rd(6'h14, r);
    check("R8 not kept", r, 32'h0);

    // R7 low half replaced and kept
    wr(6'h14, 32'hFFFF_8100);
    check("R7 no pulse", 32'(engCmd), 32'h0);
    rd(6'h14, r);
    check("R7 stored", r, 32'h0000_8100);
    wr(6'h14, 32'h0);

    // R11 busy and state
    engBusy = 1'b1; engState = 4'hC;
    rd(6'h14, r);
    check("R11", r, 32'h0061_0000);
    engBusy = 1'b0; engState = 4'h0;

    // R9 receive launches immediately
    wr(6'h14, 32'h0000_0008);
    check("R9 launch", 32'(engCmd), 32'h08);
    rd(6'h14, r);
    check("R9 not kept", r, 32'h0);

    // R4/R6 receive completes
    wr(6'h0C, 32'h0);
    wr(6'h20, 32'h0000_0077);
    evt(6'h04, 8'h5A);
    rd(6'h10, r);
    check("R4 rxdone", r, 32'h4);
    rd(6'h20, r);
    check("R6 rx byte", r, 32'h0000_5A00);
    check("R5 masked off", 32'(irq), 32'h0);
    wr(6'h0C, 32'h4);
    check("R5 enabled", 32'(irq), 32'h1);

    // R10 receive held while receive done set
    wr(6'h14, 32'h0000_0018);
    check("R10 held", 32'(engCmd), 32'h0);
    rd(6'h14, r);
    check("R10 parked", r, 32'h18);
    wr(6'h10, 32'h0000_0001);
    check("R10 other ack", 32'(engCmd), 32'h0);
    wr(6'h10, 32'h0);
    check("R10 zero ack", 32'(engCmd), 32'h0);
    rd(6'h10, r);
    check("R10 still set", r, 32'h4);
    wr(6'h10, 32'h0000_0004);
    check("R10 release", 32'(engCmd), 32'h18);
    rd(6'h14, r);
    check("R10 cleared", r, 32'h0);
    rd(6'h10, r);
    check("R3 rx acked", r, 32'h0);
    check("R5 irq low", 32'(irq), 32'h0);

    // R3 write-one-to-clear
    evt(6'h3B, 8'h00);
    rd(6'h10, r);
    check("R4 multi", r, 32'h3B);
    wr(6'h10, 32'h0000_0009);
    rd(6'h10, r);
    check("R3 w1c", r, 32'h32);

    // R4 set wins over same-cycle clear
    @(negedge clk);
    regWr = 1'b1; regAddr = 6'h10; regWdata = 32'h2; engEvt = 6'h02;
    @(negedge clk);
    regWr = 1'b0; engEvt = '0;
    rd(6'h10, r);
    check("R4 collision", r, 32'h32);

    // R6 transmit byte
    wr(6'h20, 32'hFFFF_FFA5);
    rd(6'h20, r);
    check("R6 tx", r, 32'hA5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule